// File: doc/BRIEF.md
# Single-Precision Floating-Point Divider

This block divides one IEEE-754 binary32 operand by another and returns the correctly rounded quotient with the five standard exception flags. A caller presents the dividend, the divisor and a 3-bit rounding-mode code, and pulses `start` for one cycle. The block latches everything it needs on that edge. It then works on the quotient significand one bit per clock and signals the finished result with a single-cycle `done` pulse. The result and flags stay on the outputs until the next operation finishes.

Zero, infinity and NaN operands are decoded on the start edge. Their results are chosen without running the significand datapath, but they still complete after the same number of cycles as a normal division. Subnormal operands are normalised on entry. The dividend is aligned by 30 or 31 bits, whichever places the quotient in a fixed normalised window. A restoring divider then produces 31 quotient bits, and the final remainder becomes a sticky bit that keeps inexact results distinguishable. A single rounding stage handles normal, subnormal and overflowing results.

Top module: `fp32_div`

## Requirements
- R1: While reset is asserted and after it is released, `quot`, `exc` and `done` are all zero until the first operation completes.
- R2: `done` is high for exactly one cycle, 32 clock edges after the edge that accepted `start`, whatever the operand values. `quot` and `exc` are valid while `done` is high and hold until the next completion.
- R3: A `start` pulse that arrives while an operation is in progress is ignored. It changes neither the running result nor its completion time, and it produces no extra `done`.
- R4: For finite nonzero operands, the quotient is correctly rounded and its sign is the XOR of the operand signs (bit 31).
- R5: Rounding-mode codes are 000 nearest-even, 001 toward zero, 010 toward minus infinity, 011 toward plus infinity, and 100 nearest with ties away from zero. Codes 101 to 111 act as nearest-even. Any rounded-away bits raise inexact (`exc` bit 0).
- R6: Subnormal operands are normalised before division. A result that is tiny after rounding and also inexact raises underflow (`exc` bit 1) together with inexact.
- R7: If the rounded result exceeds the largest finite value, overflow (`exc` bit 2) and inexact are raised. The result is infinity, or 0x7F7FFFFF with the operand sign when the mode rounds toward zero magnitude for that sign.
- R8: A nonzero finite value divided by zero returns an infinity with the XOR sign and raises only divide-by-zero (`exc` bit 3).
- R9: 0/0 and infinity/infinity return 0x7FC00000 and raise invalid (`exc` bit 4).
- R10: Any NaN operand gives 0x7FC00000. Invalid is raised only when an operand is a signalling NaN, that is, a NaN whose bit 22 is clear.
- R11: Finite/infinity and zero/nonzero-finite both return a zero with the XOR sign. Infinity/finite returns an infinity with the XOR sign. None of these raises a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-cycle request; accepted only when idle |
| op_a | input | 32 | Dividend, binary32 |
| op_b | input | 32 | Divisor, binary32 |
| rnd | input | 3 | Rounding-mode code (see R5) |
| quot | output | 32 | Rounded quotient, binary32 |
| exc | output | 5 | Flags: bit4 invalid, bit3 divide-by-zero, bit2 overflow, bit1 underflow, bit0 inexact |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the ties that only exist in the subnormal range. At 0x00800001/2.0, a divider that clears the wrong bit on a tie, or that ignores the ties-away mode, returns the wrong least significant bit. A result that underflows to zero is also checked, where a missing sticky bit would hide the inexact and underflow flags. Overflow is run under each rounding direction, which catches a design that always returns infinity. Quiet and signalling NaNs, the invalid pairings, and division by zero are each checked for the exact flag set, because a design that reused the overflow path for division by zero would raise overflow and inexact. Every operation also has its latency measured, and a second start is issued mid-run to show that it is ignored.

// File: rtl/fp32_div.sv
module fp32_div (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  input  logic [2:0]  rnd,
  output logic [31:0] quot,
  output logic [4:0]  exc,
  output logic        done
);

  localparam logic [31:0] QNAN = 32'h7FC00000;

  function automatic logic [4:0] top_bit(input logic [22:0] f);
    top_bit = 5'd0;
    for (int i = 0; i < 23; i++)
      if (f[i]) top_bit = i[4:0];
  endfunction

  wire [7:0]  ea = op_a[30:23];
  wire [7:0]  eb = op_b[30:23];
  wire [22:0] fa = op_a[22:0];
  wire [22:0] fb = op_b[22:0];
  wire        s0 = op_a[31] ^ op_b[31];

  wire a_nan  = (&ea) && (|fa);
  wire b_nan  = (&eb) && (|fb);
  wire a_inf  = (&ea) && !(|fa);
  wire b_inf  = (&eb) && !(|fb);
  wire a_zero = ~|op_a[30:0];
  wire b_zero = ~|op_b[30:0];
  wire a_snan = a_nan && !fa[22];
  wire b_snan = b_nan && !fb[22];

  logic [23:0]        ma, mb;
  logic signed [11:0] xa, xb;
  logic [4:0]         pa, pb;

  always_comb begin
    pa = top_bit(fa);
    pb = top_bit(fb);
    if (ea == 8'd0) begin
      ma = {1'b0, fa} << (5'd23 - pa);
      xa = $signed({7'b0, pa}) - 12'sd22;
    end else begin
      ma = {1'b1, fa};
      xa = $signed({4'b0, ea});
    end
    if (eb == 8'd0) begin
      mb = {1'b0, fb} << (5'd23 - pb);
      xb = $signed({7'b0, pb}) - 12'sd22;
    end else begin
      mb = {1'b1, fb};
      xb = $signed({4'b0, eb});
    end
  end

  wire                lt = ma < mb;
  wire signed [11:0]  x0 = xa - xb + 12'sd126 - (lt ? 12'sd1 : 12'sd0);

  logic        sp;
  logic [31:0] sp_res;
  logic [4:0]  sp_flg;

  always_comb begin
    sp     = 1'b1;
    sp_flg = 5'b0;
    sp_res = {s0, 8'hFF, 23'b0};
    if (a_nan || b_nan) begin
      sp_res = QNAN;
      sp_flg = {a_snan | b_snan, 4'b0};
    end else if ((a_inf && b_inf) || (a_zero && b_zero)) begin
      sp_res = QNAN;
      sp_flg = 5'b10000;
    end else if (a_inf) begin
      sp_res = {s0, 8'hFF, 23'b0};
    end else if (b_inf || a_zero) begin
      sp_res = {s0, 31'b0};
    end else if (b_zero) begin
      sp_res = {s0, 8'hFF, 23'b0};
      sp_flg = 5'b01000;
    end else begin
      sp = 1'b0;
    end
  end

  logic               busy, sgn, spc;
  logic [4:0]         cnt;
  logic [25:0]        rem;
  logic [23:0]        dvs;
  logic [30:0]        quo;
  logic signed [11:0] exz;
  logic [2:0]         rmr;
  logic [31:0]        spres;
  logic [4:0]         spflg;

  wire        geq = rem >= {2'b0, dvs};
  wire [25:0] nr  = geq ? rem - {2'b0, dvs} : rem;

  logic [31:0]        sg;
  logic [6:0]         inc;
  logic [25:0]        m;
  logic [7:0]         e;
  logic               tiny, ovf, ne, carry;
  logic signed [11:0] sh;
  logic [31:0]        rres;
  logic [4:0]         rflg;

  always_comb begin
    sg = {1'b0, quo};
    if (quo[5:0] == 6'd0) sg[0] = |rem;
    case (rmr)
      3'd1:    inc = 7'h00;
      3'd2:    inc = sgn ? 7'h7F : 7'h00;
      3'd3:    inc = sgn ? 7'h00 : 7'h7F;
      default: inc = 7'h40;
    endcase
    ne   = !(rmr inside {3'd1, 3'd2, 3'd3, 3'd4});
    tiny = 1'b0;
    ovf  = 1'b0;
    e    = exz[7:0];
    sh   = -exz;
    if (exz < 12'sd0) begin
      tiny = (exz < -12'sd1) || (({1'b0, sg} + {26'b0, inc}) < 33'h080000000);
      if (sh >= 12'sd31) sg = {31'b0, |sg};
      else sg = (sg >> sh[4:0]) | {31'b0, |(sg & ~(32'hFFFFFFFF << sh[4:0]))};
      e = 8'd0;
    end else if (exz > 12'sd253 ||
                 (exz == 12'sd253 && ({1'b0, sg} + {26'b0, inc}) >= 33'h080000000)) begin
      ovf = 1'b1;
    end
    carry = ({1'b0, sg[6:0]} + {1'b0, inc}) > 8'h7F;
    m     = {1'b0, sg[31:7]} + {25'b0, carry};
    if (ne && sg[6:0] == 7'h40) m[0] = 1'b0;
    if (m == 26'd0) e = 8'd0;
    rres = {sgn, e, 23'b0} + {6'b0, m};
    rflg = {3'b0, tiny && (|sg[6:0]), |sg[6:0]};
    if (ovf) begin
      rres = {sgn, 8'hFF, 23'b0} - {31'b0, inc == 7'd0};
      rflg = 5'b00101;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= 5'd0;
      rem   <= '0;
      dvs   <= '0;
      quo   <= '0;
      sgn   <= 1'b0;
      exz   <= '0;
      rmr   <= 3'd0;
      spc   <= 1'b0;
      spres <= '0;
      spflg <= '0;
      quot  <= '0;
      exc   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy  <= 1'b1;
          cnt   <= 5'd0;
          rem   <= lt ? {1'b0, ma, 1'b0} : {2'b0, ma};
          dvs   <= mb;
          quo   <= '0;
          sgn   <= s0;
          exz   <= x0;
          rmr   <= rnd;
          spc   <= sp;
          spres <= sp_res;
          spflg <= sp_flg;
        end
      end else if (cnt == 5'd31) begin
        busy <= 1'b0;
        done <= 1'b1;
        quot <= spc ? spres : rres;
        exc  <= spc ? spflg : rflg;
      end else begin
        quo <= {quo[29:0], geq};
        rem <= {nr[24:0], 1'b0};
        cnt <= cnt + 5'd1;
      end
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R2
  done_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));

  // R3
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(dvs) && $stable(exz) && $stable(rmr)));

  // R10
  nan_canon_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (&quot[30:23]) && (|quot[22:0])) |-> quot == QNAN);

  // R7
  ovf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exc[2]) |-> exc[0]);

  // R6
  uf_inexact_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exc[1]) |-> exc[0]);

  // R8
  dz_inf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && exc[3]) |-> (quot[30:0] == 31'h7F800000 && exc[2:0] == 3'b0));

endmodule

// File: tb/fp32_div_test.sv
`timescale 1ns/1ps
module fp32_div_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic [2:0]  rm = 3'd0;
  logic [31:0] quot;
  logic [4:0]  exc;
  logic        done;
  int          checks = 0, errors = 0;
  bit          ended = 1'b0;

  fp32_div uut (.clk(clk), .rst_n(rst_n), .start(start), .op_a(a), .op_b(b),
                .rnd(rm), .quot(quot), .exc(exc), .done(done));

  always #10 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [31:0] x, input logic [31:0] y, input logic [2:0] m,
                     input logic [31:0] er, input logic [4:0] ef, input string req);
    int n;
    @(negedge clk);
    a = x; b = y; rm = m; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 100) begin
      @(negedge clk);
      n++;
    end
    chk(n == 32, {"R2 latency ", req}, 32'(n), 32'd32);
    chk(quot == er, {req, " result"}, quot, er);
    chk(exc == ef, {req, " flags"}, {27'b0, exc}, {27'b0, ef});
    @(negedge clk);
    chk(!done, "R2 single pulse", {31'b0, done}, 32'd0);
    chk(quot == er, "R2 hold", quot, er);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(quot == 0 && exc == 0 && !done, "R1 reset outputs", quot | {27'b0, exc} | {31'b0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(quot == 0 && exc == 0 && !done, "R1 after release", quot | {27'b0, exc} | {31'b0, done}, 32'd0);
  endtask

  task automatic t_exact;
    run(32'h40C00000, 32'h40000000, 3'd0, 32'h40400000, 5'h00, "R4 6/2");
    run(32'hC0C00000, 32'h40000000, 3'd0, 32'hC0400000, 5'h00, "R4 -6/2 sign");
    run(32'h40000000, 32'h40400000, 3'd0, 32'h3F2AAAAB, 5'h01, "R4 2/3");
  endtask

  task automatic t_modes;
    run(32'h3F800000, 32'h40400000, 3'd0, 32'h3EAAAAAB, 5'h01, "R5 1/3 nearest-even");
    run(32'h3F800000, 32'h40400000, 3'd1, 32'h3EAAAAAA, 5'h01, "R5 1/3 toward zero");
    run(32'h3F800000, 32'h40400000, 3'd2, 32'h3EAAAAAA, 5'h01, "R5 1/3 down");
    run(32'h3F800000, 32'h40400000, 3'd3, 32'h3EAAAAAB, 5'h01, "R5 1/3 up");
    run(32'hBF800000, 32'h40400000, 3'd2, 32'hBEAAAAAB, 5'h01, "R5 -1/3 down");
    run(32'hBF800000, 32'h40400000, 3'd3, 32'hBEAAAAAA, 5'h01, "R5 -1/3 up");
  endtask

  task automatic t_subnormal;
    run(32'h00800001, 32'h40000000, 3'd0, 32'h00400000, 5'h03, "R6 tie nearest-even");
    run(32'h00800001, 32'h40000000, 3'd4, 32'h00400001, 5'h03, "R5 tie away");
    run(32'h00800001, 32'h40000000, 3'd3, 32'h00400001, 5'h03, "R6 tie up");
    run(32'h00000001, 32'h00000002, 3'd0, 32'h3F000000, 5'h00, "R6 subnormal operands");
    run(32'h3F800000, 32'h00400000, 3'd0, 32'h7F000000, 5'h00, "R6 subnormal divisor");
    run(32'h00000001, 32'h40800000, 3'd0, 32'h00000000, 5'h03, "R6 underflow to zero");
    run(32'h00000001, 32'h40800000, 3'd3, 32'h00000001, 5'h03, "R6 underflow up");
  endtask

  task automatic t_overflow;
    run(32'h7F7FFFFF, 32'h3F000000, 3'd0, 32'h7F800000, 5'h05, "R7 overflow nearest");
    run(32'h7F7FFFFF, 32'h3F000000, 3'd1, 32'h7F7FFFFF, 5'h05, "R7 overflow toward zero");
    run(32'h7F7FFFFF, 32'h3F000000, 3'd2, 32'h7F7FFFFF, 5'h05, "R7 overflow down");
    run(32'hFF7FFFFF, 32'h3F000000, 3'd2, 32'hFF800000, 5'h05, "R7 neg overflow down");
  endtask

  task automatic t_special;
    run(32'h3F800000, 32'h00000000, 3'd0, 32'h7F800000, 5'h08, "R8 1/0");
    run(32'hC0000000, 32'h00000000, 3'd0, 32'hFF800000, 5'h08, "R8 -2/0");
    run(32'h00000000, 32'h80000000, 3'd0, 32'h7FC00000, 5'h10, "R9 0/0");
    run(32'h7F800000, 32'hFF800000, 3'd0, 32'h7FC00000, 5'h10, "R9 inf/inf");
    run(32'h7F800001, 32'h3F800000, 3'd0, 32'h7FC00000, 5'h10, "R10 signalling NaN");
    run(32'h3F800000, 32'hFFC00001, 3'd0, 32'h7FC00000, 5'h00, "R10 quiet NaN");
    run(32'h40000000, 32'hFF800000, 3'd0, 32'h80000000, 5'h00, "R11 finite/inf");
    run(32'hFF800000, 32'h40000000, 3'd0, 32'hFF800000, 5'h00, "R11 inf/finite");
    run(32'h00000000, 32'hC0000000, 3'd0, 32'h80000000, 5'h00, "R11 zero/finite");
  endtask

  task automatic t_busy;
    int  n;
    bit  extra;
    @(negedge clk);
    a = 32'h3F800000; b = 32'h40400000; rm = 3'd0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    repeat (5) begin @(negedge clk); n++; end
    a = 32'h40C00000; b = 32'h40000000; rm = 3'd1; start = 1'b1;
    @(negedge clk);
    n++;
    start = 1'b0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    chk(n == 32, "R3 latency unchanged", 32'(n), 32'd32);
    chk(quot == 32'h3EAAAAAB, "R3 result unchanged", quot, 32'h3EAAAAAB);
    extra = 1'b0;
    repeat (40) begin @(negedge clk); if (done) extra = 1'b1; end
    chk(!extra, "R3 no extra done", {31'b0, extra}, 32'd0);
  endtask

  initial begin
    t_reset;
    t_exact;
    t_modes;
    t_subnormal;
    t_overflow;
    t_special;
    t_busy;
    ended = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      errors++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule